// File: doc/BRIEF.md
# PWM Overcurrent Stop Controller

This block sits between an overcurrent comparator and a three-phase PWM generator. It decides when the high-side and low-side drive signals must be forced inactive. It takes the raw comparator output, which idles high and falls when the current limit is exceeded. It passes that signal through a synchroniser and a debounce filter with a binary-scaled hold time. The debounced level is then applied to one of eight stop policies. A policy is either latched or self-recovering, and it gates either the high side only or both sides.

The PWM generator ANDs its gate drives with the inverse of `suppress_high_o` and `suppress_low_o`. The comparator is optional as a source: an external interrupt line and a software stop command can also force a stop. A latched stop ends only when software pulses the clear input. Every debounced comparator transition, in either direction, raises a one-cycle interrupt pulse.

Top module: `pwm_fault_stop`

## Requirements
- R1: The comparator input passes through 2 synchronising flops. The debounced level takes a new value only after the synchronised input has differed from it for N consecutive cycles. N is set by `dly_code_i`: code 0 gives N=1 (no added delay), code c in 1..8 gives N=2^(c+1) (4 to 512), and codes 9..15 give N=1024.
- R2: While `rst_ni` is low, both suppress outputs and `fault_irq_o` are 0, and the debounced level is held high (idle, no overcurrent).
- R3: `fault_irq_o` is high for exactly one cycle in the cycle in which the debounced level changes, for falling and rising transitions alike.
- R4: With `stop_mode_i`=000, comparator transitions and `ext_irq_i` have no effect on the suppress outputs; only `sw_stop_i` stops them.
- R5: Modes 001, 010 and 011 latch suppression of both sides. Mode 001 latches on a debounced falling edge. Mode 010 latches on any cycle with `ext_irq_i` high. Mode 011 latches on either source.
- R6: Mode 100 suppresses both sides on a debounced falling edge and releases them on the next debounced rising edge, with no software action.
- R7: Mode 101 suppresses only the high side on a debounced falling edge and releases it on the next debounced rising edge.
- R8: Mode 110 latches suppression of the high side only on a debounced falling edge. Mode 111 latches suppression of both sides.
- R9: A `sw_stop_i` pulse latches suppression of both sides in every mode. A `sw_clr_i` pulse clears all latched suppression one cycle later. When a stop event and a clear occur in the same cycle, the stop wins.
- R10: `suppress_low_o` is never high while `suppress_high_o` is low.
- R11: Self-recovering suppression from modes 100 and 101 is dropped once the mode leaves those codes. Mode 101 never holds the low side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | 1 | Raw comparator output, low means overcurrent |
| ext_irq_i | input | 1 | External stop request, synchronous, active high |
| sw_stop_i | input | 1 | Software stop command pulse |
| sw_clr_i | input | 1 | Software clear of latched stops |
| stop_mode_i | input | 3 | Stop policy code |
| dly_code_i | input | 4 | Debounce hold time code |
| suppress_high_o | output | 1 | Force high-side drives inactive |
| suppress_low_o | output | 1 | Force low-side drives inactive |
| fault_irq_o | output | 1 | One-cycle pulse on each debounced comparator transition |

## Verification
The hardest situations to reach are at the edge of the debounce window. One is a comparator glitch that lasts exactly one cycle less than the selected hold time. Another is a glitch at the longest 1024-cycle setting that ends one cycle short. The bench drives such glitches right after glitches that last the full window, so that a counter that is off by one in either direction changes the irq and suppress timing. It also switches the mode while a self-recovering stop is active, and pulses stop and clear in the same cycle. A cycle-accurate behavioural model is compared against the outputs on every clock.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  typedef enum logic [2:0] {
    STOP_SW_ONLY     = 3'b000,
    STOP_CMP_LATCH   = 3'b001,
    STOP_EXT_LATCH   = 3'b010,
    STOP_ANY_LATCH   = 3'b011,
    STOP_FOLLOW_BOTH = 3'b100,
    STOP_FOLLOW_HI   = 3'b101,
    STOP_LATCH_HI    = 3'b110,
    STOP_LATCH_BOTH  = 3'b111
  } stop_mode_e;
endpackage

// File: rtl/pwm_fault_sync.sv
module pwm_fault_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pwm_fault_debounce.sv
module pwm_fault_debounce #(
  parameter int CODE_W  = 4,
  parameter int MAX_EXP = 10,
  localparam int CNT_W  = MAX_EXP + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              level_i,
  input  logic [CODE_W-1:0] dly_code_i,
  output logic              level_o,
  output logic              fall_o,
  output logic              rise_o
);
  logic [CNT_W-1:0] need, cnt_q, cnt_inc;
  logic             lvl_q, fall_q, rise_q;

  // code 0 -> 1 sample, 1..MAX_EXP-1 -> 2^(c+1), rest saturate
  always_comb begin
    if (int'(dly_code_i) == 0)            need = CNT_W'(1);
    else if (int'(dly_code_i) < MAX_EXP)  need = CNT_W'(1) << (int'(dly_code_i) + 1);
    else                                  need = CNT_W'(1) << MAX_EXP;
  end

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      if (level_i != lvl_q) begin
        if (cnt_inc >= need) begin
          lvl_q  <= level_i;
          fall_q <= ~level_i;
          rise_q <= level_i;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign level_o = lvl_q;
  assign fall_o  = fall_q;
  assign rise_o  = rise_q;

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < (CNT_W'(1) << MAX_EXP)); // R1
  AST_LEVEL_FROM_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> (lvl_q == $past(level_i))); // R1
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_q || rise_q) |-> !$stable(lvl_q)); // R3
endmodule

// File: rtl/pwm_fault_policy.sv
module pwm_fault_policy
  import pwm_fault_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  stop_mode_e mode_i,
  input  logic       fall_i,
  input  logic       rise_i,
  input  logic       ext_i,
  input  logic       sw_stop_i,
  input  logic       sw_clr_i,
  output logic       sup_hi_o,
  output logic       sup_lo_o
);
  logic cmp_both, ext_en, cmp_hi, follow_both, follow_hi;
  logic set_both, set_hi;
  logic lat_hi_q, lat_lo_q, tr_hi_q, tr_lo_q;

  assign cmp_both    = mode_i inside {STOP_CMP_LATCH, STOP_ANY_LATCH, STOP_LATCH_BOTH};
  assign ext_en      = mode_i inside {STOP_EXT_LATCH, STOP_ANY_LATCH};
  assign cmp_hi      = (mode_i == STOP_LATCH_HI);
  assign follow_both = (mode_i == STOP_FOLLOW_BOTH);
  assign follow_hi   = follow_both | (mode_i == STOP_FOLLOW_HI);

  assign set_both = sw_stop_i | (fall_i & cmp_both) | (ext_i & ext_en);
  assign set_hi   = set_both | (fall_i & cmp_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_hi_q <= 1'b0;
      lat_lo_q <= 1'b0;
      tr_hi_q  <= 1'b0;
      tr_lo_q  <= 1'b0;
    end else begin
      if (set_hi)        lat_hi_q <= 1'b1;
      else if (sw_clr_i) lat_hi_q <= 1'b0;
      if (set_both)      lat_lo_q <= 1'b1;
      else if (sw_clr_i) lat_lo_q <= 1'b0;

      if (!follow_hi)  tr_hi_q <= 1'b0;
      else if (fall_i) tr_hi_q <= 1'b1;
      else if (rise_i) tr_hi_q <= 1'b0;

      if (!follow_both) tr_lo_q <= 1'b0;
      else if (fall_i)  tr_lo_q <= 1'b1;
      else if (rise_i)  tr_lo_q <= 1'b0;
    end
  end

  assign sup_hi_o = lat_hi_q | tr_hi_q;
  assign sup_lo_o = lat_lo_q | tr_lo_q;

  AST_SW_STOP_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_stop_i |=> (sup_hi_o && sup_lo_o)); // R9
  AST_LATCH_BOTH_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && mode_i == STOP_LATCH_BOTH) |=> (sup_hi_o && sup_lo_o)); // R8
  AST_LO_IMPLIES_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_lo_o |-> sup_hi_o); // R10
  AST_FOLLOW_HI_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && mode_i == STOP_FOLLOW_HI && !sw_stop_i && sw_clr_i) |=> !sup_hi_o); // R7
endmodule

// File: rtl/pwm_fault_stop.sv
module pwm_fault_stop
  import pwm_fault_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_CODE_W  = 4,
  parameter int MAX_EXP     = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmp_raw_i,
  input  logic                  ext_irq_i,
  input  logic                  sw_stop_i,
  input  logic                  sw_clr_i,
  input  logic [2:0]            stop_mode_i,
  input  logic [DLY_CODE_W-1:0] dly_code_i,
  output logic                  suppress_high_o,
  output logic                  suppress_low_o,
  output logic                  fault_irq_o
);
  logic cmp_sync, cmp_lvl, cmp_fall, cmp_rise;

  pwm_fault_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (cmp_sync)
  );

  pwm_fault_debounce #(.CODE_W(DLY_CODE_W), .MAX_EXP(MAX_EXP)) u_debounce (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (cmp_sync),
    .dly_code_i(dly_code_i),
    .level_o   (cmp_lvl),
    .fall_o    (cmp_fall),
    .rise_o    (cmp_rise)
  );

  pwm_fault_policy u_policy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (stop_mode_e'(stop_mode_i)),
    .fall_i   (cmp_fall),
    .rise_i   (cmp_rise),
    .ext_i    (ext_irq_i),
    .sw_stop_i(sw_stop_i),
    .sw_clr_i (sw_clr_i),
    .sup_hi_o (suppress_high_o),
    .sup_lo_o (suppress_low_o)
  );

  assign fault_irq_o = cmp_fall | cmp_rise;

  AST_IRQ_MATCHES_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_irq_o |-> (cmp_lvl != $past(cmp_lvl))); // R3
  AST_FALL_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_fall |-> !cmp_lvl); // R3
endmodule

// File: tb/pwm_fault_stop_tb_top.sv
module pwm_fault_stop_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b1, ext_irq = 1'b0, sw_stop = 1'b0, sw_clr = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [3:0] dly = 4'd0;
  logic       sup_hi, sup_lo, irq;

  int    checks = 0, errors = 0, cyc = 0;
  string cur_req = "R2";

  always #10 clk = ~clk;

  pwm_fault_stop dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_raw_i(cmp_raw), .ext_irq_i(ext_irq),
    .sw_stop_i(sw_stop), .sw_clr_i(sw_clr), .stop_mode_i(mode), .dly_code_i(dly),
    .suppress_high_o(sup_hi), .suppress_low_o(sup_lo), .fault_irq_o(irq)
  );

  // behavioural reference model
  bit sq[$];
  bit m_db, m_fall, m_rise, m_lh, m_ll, m_th, m_tl;
  int run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq = '{1'b1, 1'b1};
      m_db = 1; run = 0; m_fall = 0; m_rise = 0;
      m_lh = 0; m_ll = 0; m_th = 0; m_tl = 0;
    end else begin
      bit setb, seth, s_old;
      int need;
      setb = sw_stop || (m_fall && (mode == 1 || mode == 3 || mode == 7)) ||
             (ext_irq && (mode == 2 || mode == 3));
      seth = setb || (m_fall && mode == 6);
      if (seth) m_lh = 1; else if (sw_clr) m_lh = 0;
      if (setb) m_ll = 1; else if (sw_clr) m_ll = 0;
      if (mode == 4) begin
        if (m_fall) begin m_th = 1; m_tl = 1; end
        else if (m_rise) begin m_th = 0; m_tl = 0; end
      end else if (mode == 5) begin
        m_tl = 0;
        if (m_fall) m_th = 1; else if (m_rise) m_th = 0;
      end else begin
        m_th = 0; m_tl = 0;
      end
      s_old = sq.pop_front();
      sq.push_back(cmp_raw);
      need = (dly == 0) ? 1 : (dly >= 9) ? 1024 : (1 << (dly + 1));
      m_fall = 0; m_rise = 0;
      if (s_old != m_db) begin
        run++;
        if (run >= need) begin
          m_fall = !s_old; m_rise = s_old; m_db = s_old; run = 0;
        end
      end else run = 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (sup_hi !== (m_lh | m_th) || sup_lo !== (m_ll | m_tl) || irq !== (m_fall | m_rise)) begin
        errors++;
        $display("FAIL %s cycle %0d: hi/lo/irq actual %b%b%b expected %b%b%b", cur_req, cyc,
                 sup_hi, sup_lo, irq, m_lh | m_th, m_ll | m_tl, m_fall | m_rise);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold(bit v, int n);
    cmp_raw = v; step(n);
  endtask

  task automatic pulse_stop(); sw_stop = 1; step(); sw_stop = 0; endtask
  task automatic pulse_clr();  sw_clr = 1;  step(); sw_clr = 0;  endtask

  task automatic expect_out(bit hi, bit lo, string tag);
    checks++;
    if (sup_hi !== hi || sup_lo !== lo) begin
      errors++;
      $display("FAIL %s: hi/lo actual %b%b expected %b%b", tag, sup_hi, sup_lo, hi, lo);
    end
  endtask

  initial begin
    step(2);
    expect_out(0, 0, "R2");
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R2: irq actual %b expected 0", irq); end
    rst_n = 1; step(2);

    // R4 / R1 / R3: glitch one short of window, then full window
    cur_req = "R4"; mode = 3'b000; dly = 4'd2;
    hold(0, 7); hold(1, 20); hold(0, 30); hold(1, 30);
    ext_irq = 1; step(); ext_irq = 0; step(3);
    expect_out(0, 0, "R4");
    cur_req = "R1"; hold(0, 8); hold(1, 20);

    // R9 software stop and clear
    cur_req = "R9"; pulse_stop(); expect_out(1, 1, "R9");
    step(3); pulse_clr(); expect_out(0, 0, "R9");
    sw_stop = 1; sw_clr = 1; step(); sw_stop = 0; sw_clr = 0;
    expect_out(1, 1, "R9"); pulse_clr();

    // R5 latching modes
    cur_req = "R5"; mode = 3'b001; dly = 4'd0;
    ext_irq = 1; step(); ext_irq = 0; step(2); expect_out(0, 0, "R5");
    hold(0, 6); hold(1, 6); expect_out(1, 1, "R5"); pulse_clr(); expect_out(0, 0, "R5");
    mode = 3'b010; hold(0, 6); hold(1, 6); expect_out(0, 0, "R5");
    ext_irq = 1; step(); ext_irq = 0; expect_out(1, 1, "R5"); pulse_clr();
    mode = 3'b011; hold(0, 6); expect_out(1, 1, "R5"); pulse_clr(); hold(1, 6);
    ext_irq = 1; step(); ext_irq = 0; expect_out(1, 1, "R5"); pulse_clr();

    // R6 follow both
    cur_req = "R6"; mode = 3'b100; dly = 4'd1;
    hold(0, 10); expect_out(1, 1, "R6"); hold(1, 10); expect_out(0, 0, "R6");
    hold(0, 3); hold(1, 10); expect_out(0, 0, "R6");

    // R7 follow high only
    cur_req = "R7"; mode = 3'b101;
    hold(0, 10); expect_out(1, 0, "R7"); hold(1, 10); expect_out(0, 0, "R7");

    // R11 mode change drops transient stop
    cur_req = "R11"; mode = 3'b100; hold(0, 10); expect_out(1, 1, "R11");
    mode = 3'b101; step(2); expect_out(1, 0, "R11");
    mode = 3'b000; step(2); expect_out(0, 0, "R11"); hold(1, 10);

    // R8 latched high / both, R10 invariant exercised throughout
    cur_req = "R8"; mode = 3'b110; dly = 4'd3;
    hold(0, 20); hold(1, 20); expect_out(1, 0, "R8"); pulse_clr(); expect_out(0, 0, "R8");
    mode = 3'b111; hold(0, 20); hold(1, 20); expect_out(1, 1, "R8");
    cur_req = "R10"; pulse_clr(); expect_out(0, 0, "R10");

    // R1 saturated delay: one short, then full
    cur_req = "R1"; mode = 3'b100; dly = 4'd12;
    hold(0, 1023); hold(1, 20); expect_out(0, 0, "R1");
    hold(0, 1030); expect_out(1, 1, "R1"); hold(1, 1030); expect_out(0, 0, "R1");
    dly = 4'd9; hold(0, 1030); expect_out(1, 1, "R1"); hold(1, 1030);

    // R3 back-to-back edges with zero delay
    cur_req = "R3"; dly = 4'd0; mode = 3'b000;
    hold(0, 1); hold(1, 1); hold(0, 1); hold(1, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule